// File: doc/BRIEF.md
# External Interrupt Sense and Flag Unit

This block watches a small set of external interrupt pins on behalf of a processor core. Each pin passes through a two-stage synchronizer. A per-pin two-bit sense field then selects the trigger condition: a low level, any change, a falling edge or a rising edge. Edge conditions latch a per-pin flag. The low-level condition drives the request directly for as long as the pin stays low.

A pending condition becomes a request only when the pin's own enable bit is set and the master enable bit is set. The highest-priority request, which is the lowest pin number, is presented to the core together with its index. A flag clears when the core acknowledges that index, or when software writes 1 to the flag bit. All control state is loaded through a single-cycle write port with a two-bit address.

Top module: `extint_unit`

## Requirements
- R1: After reset every flag, every per-pin request and the core request are 0. All enables are 0 and every sense field is 00.
- R2: Address 0 loads the sense register. Pin k's field sits in write-data bits 2k+1:2k, so pin 0 uses bits 1:0 and pin 1 uses bits 3:2. Code 00 requests while the synchronized pin is low and latches no flag.
- R3: Sense code 01 sets the pin's flag on every change of the synchronized pin, in either direction.
- R4: Sense code 10 sets the flag on a high-to-low change only. A low-to-high change leaves the flag as it was.
- R5: Sense code 11 sets the flag on a low-to-high change only. A high-to-low change leaves the flag as it was.
- R6: Address 1 loads the per-pin enables, with bit k for pin k. A pin whose enable is 0 raises no request, but its flag is still latched.
- R7: Address 3 bit 0 is the master enable. While it is 0 there is no per-pin request and no core request.
- R8: When the acknowledge input is high, the flag of the acknowledged index clears on that clock edge. An index at or above the pin count is ignored.
- R9: At address 2, writing 1 to bit k clears flag k. A 0 bit leaves its flag unchanged.
- R10: When several requests are active, the core request index is the lowest-numbered requesting pin.
- R11: A pin change applied before clock edge e sets its flag after edge e+2. Two edges are spent synchronizing and one latching the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | External interrupt pins, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 sense, 1 enables, 2 flag clear, 3 master enable |
| wr_data_i | input | 2*NUM_PINS | Write data |
| ack_i | input | 1 | Core acknowledges service |
| ack_id_i | input | IDW | Index being acknowledged |
| flag_o | output | NUM_PINS | Latched edge flags |
| req_o | output | NUM_PINS | Per-pin gated requests |
| cpu_irq_o | output | 1 | Request to the core |
| cpu_irq_id_o | output | IDW | Index of the winning request |

## Verification
The bench targets the exact flag latency through the synchronizer. A design with one stage too few or too many would show the flag a cycle early or late.

It also checks that the edge modes ignore the opposite direction, which a swapped decode of codes 10 and 11 would break. Low-level mode must hold the request without latching a flag, so the request must drop on release. Flags must still latch while a pin is disabled, and a gated-flag design would lose those events.

Acknowledges to an out-of-range index must clear nothing. Simultaneous requests must resolve to the lowest index, which an inverted priority scan would get wrong.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // Edge event for one pin given its mode, current and previous synchronized level.
  function automatic logic edge_event(sense_e mode, logic cur, logic prev);
    case (mode)
      SENSE_ANY:  edge_event = cur ^ prev;
      SENSE_FALL: edge_event = prev & ~cur;
      SENSE_RISE: edge_event = cur & ~prev;
      default:    edge_event = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int NUM_PINS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] sync_o
);
  logic [NUM_PINS-1:0] stage1_q, stage2_q;

  // Idle level of the pins is high, so the stages reset high.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= pin_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   sync_i,
  input  logic [2*NUM_PINS-1:0] sense_i,
  output logic [NUM_PINS-1:0]   evt_o,
  output logic [NUM_PINS-1:0]   level_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= sync_i;
  end

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    sense_e mode;
    assign mode       = sense_e'(sense_i[2*k +: 2]);
    assign evt_o[k]   = edge_event(mode, sync_i[k], prev_q[k]);
    assign level_o[k] = (mode == SENSE_LOW) & ~sync_i[k];
  end
endmodule

// File: rtl/extint_prio.sv
module extint_prio #(
  parameter int NUM_PINS = 3,
  parameter int IDW      = 2
) (
  input  logic [NUM_PINS-1:0] req_i,
  output logic                any_o,
  output logic [IDW-1:0]      id_o
);
  assign any_o = |req_i;

  // Scan from the top so the lowest index is written last and wins.
  always_comb begin
    id_o = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = IDW'(i);
    end
  end
endmodule

// File: rtl/extint_unit.sv
module extint_unit
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 3,
  localparam int IDW     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int DW      = 2 * NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic                ack_i,
  input  logic [IDW-1:0]      ack_id_i,
  output logic [NUM_PINS-1:0] flag_o,
  output logic [NUM_PINS-1:0] req_o,
  output logic                cpu_irq_o,
  output logic [IDW-1:0]      cpu_irq_id_o
);
  localparam logic [1:0] ADDR_SENSE = 2'd0;
  localparam logic [1:0] ADDR_EN    = 2'd1;
  localparam logic [1:0] ADDR_CLR   = 2'd2;
  localparam logic [1:0] ADDR_GIE   = 2'd3;

  logic [DW-1:0]       sense_q;
  logic [NUM_PINS-1:0] en_q, flag_q;
  logic                gie_q;

  // Named internal events, also observed by the checker.
  logic [NUM_PINS-1:0] sync_w, evt_w, level_w, clr_sw_w, clr_ack_w, pend_w;

  extint_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .sync_o(sync_w)
  );

  extint_sense #(.NUM_PINS(NUM_PINS)) u_sense (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_w),
    .sense_i(sense_q),
    .evt_o  (evt_w),
    .level_o(level_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      en_q    <= '0;
      gie_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_SENSE: sense_q <= wr_data_i;
        ADDR_EN:    en_q    <= wr_data_i[NUM_PINS-1:0];
        ADDR_GIE:   gie_q   <= wr_data_i[0];
        default:    ;
      endcase
    end
  end

  assign clr_sw_w  = (wr_en_i && wr_addr_i == ADDR_CLR) ? wr_data_i[NUM_PINS-1:0] : '0;
  assign clr_ack_w = (ack_i && 32'(ack_id_i) < NUM_PINS)
                   ? (NUM_PINS'(1) << ack_id_i) : '0;

  // A fresh event outranks a clear arriving on the same edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~(clr_sw_w | clr_ack_w)) | evt_w;
  end

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pend
    assign pend_w[k] = (sense_q[2*k +: 2] == SENSE_LOW) ? level_w[k] : flag_q[k];
  end

  assign req_o  = pend_w & en_q & {NUM_PINS{gie_q}};
  assign flag_o = flag_q;

  extint_prio #(.NUM_PINS(NUM_PINS), .IDW(IDW)) u_prio (
    .req_i(req_o), .any_o(cpu_irq_o), .id_o(cpu_irq_id_o)
  );
endmodule

// File: rtl/extint_unit_chk.sv
module extint_unit_chk #(
  parameter int NUM_PINS = 3,
  parameter int IDW      = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] flag_q,
  input logic [NUM_PINS-1:0] evt_w,
  input logic [NUM_PINS-1:0] en_q,
  input logic                gie_q,
  input logic [NUM_PINS-1:0] req_o,
  input logic                cpu_irq_o,
  input logic [IDW-1:0]      cpu_irq_id_o,
  input logic                ack_i,
  input logic [IDW-1:0]      ack_id_i
);
  logic [NUM_PINS-1:0] ack_mask;
  assign ack_mask = (ack_i && 32'(ack_id_i) < NUM_PINS) ? (NUM_PINS'(1) << ack_id_i) : '0;

  // R3 R4 R5: a detected edge leaves its flag set on the next cycle
  a_r3_event_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_w != 0) |=> ((flag_q & $past(evt_w)) == $past(evt_w)));

  // R2: no flag rises without an edge event
  a_r2_flag_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & ~$past(flag_q) & ~$past(evt_w)) == 0));

  // R6: disabled pins raise nothing
  a_r6_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_o & ~en_q) == 0));

  // R7: master enable low blocks the core request
  a_r7_master_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |-> !cpu_irq_o);

  // R10: winner is a requester with no lower requester
  a_r10_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o |-> (req_o[cpu_irq_id_o] &&
                   ((req_o & ~({NUM_PINS{1'b1}} << cpu_irq_id_o)) == 0)));

  // R8: acknowledged flag is clear afterwards unless re-triggered
  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ack_mask & ~evt_w) != 0) |=> ((flag_q & $past(ack_mask & ~evt_w)) == 0));
endmodule

bind extint_unit extint_unit_chk #(.NUM_PINS(NUM_PINS), .IDW(IDW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flag_q(flag_q), .evt_w(evt_w),
  .en_q(en_q), .gie_q(gie_q), .req_o(req_o), .cpu_irq_o(cpu_irq_o),
  .cpu_irq_id_o(cpu_irq_id_o), .ack_i(ack_i), .ack_id_i(ack_id_i)
);

// File: tb/extint_unit_bench.sv
`timescale 1ns/1ps
module extint_unit_bench;
  localparam int N = 3;
  localparam int IDW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pins = '1;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [2*N-1:0] wr_data = 0;
  logic ack = 0;
  logic [IDW-1:0] ack_id = 0;
  logic [N-1:0] flag, req;
  logic cpu_irq;
  logic [IDW-1:0] cpu_id;

  int checks = 0, fails = 0;
  logic [2*N-1:0] m_sense = 0;
  logic [N-1:0] m_en = 0, m_flag = 0, m_pin = '1;
  logic m_gie = 0;

  always #2 clk = ~clk;

  extint_unit u_extint_unit (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ack_i(ack), .ack_id_i(ack_id), .flag_o(flag),
    .req_o(req), .cpu_irq_o(cpu_irq), .cpu_irq_id_o(cpu_id)
  );

  function automatic logic b_event(logic [1:0] mode, logic was, logic now);
    if (mode == 2'b01) return was != now;
    if (mode == 2'b10) return was && !now;
    if (mode == 2'b11) return !was && now;
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] b_req();
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) begin
      logic p;
      p = (m_sense[2*k +: 2] == 2'b00) ? !m_pin[k] : m_flag[k];
      r[k] = p && m_en[k] && m_gie;
    end
    return r;
  endfunction

  function automatic int b_id(logic [N-1:0] r);
    for (int k = 0; k < N; k++) if (r[k]) return k;
    return 0;
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string rq);
    logic [N-1:0] er;
    er = b_req();
    chk(flag == m_flag, {rq, " flags"}, int'(flag), int'(m_flag));
    chk(req == er, {rq, " req"}, int'(req), int'(er));
    chk(cpu_irq == (er != 0), {rq, " cpu_irq"}, int'(cpu_irq), int'(er != 0));
    if (er != 0) chk(int'(cpu_id) == b_id(er), {rq, " id"}, int'(cpu_id), b_id(er));
  endtask

  task automatic wr(logic [1:0] a, logic [2*N-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    case (a)
      2'd0: m_sense = d;
      2'd1: m_en = d[N-1:0];
      2'd2: m_flag = m_flag & ~d[N-1:0];
      default: m_gie = d[0];
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_pin(int k, logic v);
    @(negedge clk);
    if (b_event(m_sense[2*k +: 2], m_pin[k], v)) m_flag[k] = 1'b1;
    m_pin[k] = v; pins[k] = v;
  endtask

  task automatic do_ack(logic [IDW-1:0] id);
    @(negedge clk);
    ack = 1; ack_id = id;
    if (int'(id) < N) m_flag[id] = 1'b0;
    @(negedge clk);
    ack = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    cyc(3); rst_n = 1; cyc(1);
    check_all("R1 reset");

    wr(2'd3, 1); wr(2'd1, '1);
    // R11 exact latency, R4 falling mode on pin 0
    wr(2'd0, 6'b00_00_10);
    set_pin(0, 0);
    cyc(2); chk(flag[0] == 0, "R11 flag not before third edge", flag[0], 0);
    cyc(1); chk(flag[0] == 1, "R11 flag after third edge", flag[0], 1);
    check_all("R4 falling");
    do_ack(0); check_all("R8 ack clears");
    set_pin(0, 1); cyc(4); check_all("R4 rising ignored");
    do_ack(3); check_all("R8 out-of-range ack");

    // R5 rising mode
    wr(2'd0, 6'b00_00_11);
    set_pin(0, 0); cyc(4); check_all("R5 falling ignored");
    set_pin(0, 1); cyc(4); check_all("R5 rising");
    wr(2'd2, 6'b000_110); check_all("R9 zero bit keeps flag");
    wr(2'd2, 6'b000_001); check_all("R9 one bit clears");

    // R3 any change on pin 1 (field bits 3:2)
    wr(2'd0, 6'b00_01_00);
    set_pin(1, 0); cyc(4); check_all("R3 any change low");
    wr(2'd2, 6'b000_010);
    set_pin(1, 1); cyc(4); check_all("R3 any change high");

    // R2 low level on pin 2: request without flag
    set_pin(2, 0); cyc(4); check_all("R2 level low");
    chk(flag[2] == 0, "R2 no flag", flag[2], 0);
    set_pin(2, 1); cyc(4); check_all("R2 level released");

    // R6 disabled pin still latches
    wr(2'd1, 3'b101); wr(2'd2, 6'b000_111);
    set_pin(1, 0); cyc(4); check_all("R6 disabled pin");
    chk(flag[1] == 1 && req[1] == 0, "R6 flag kept, no req", {flag[1], req[1]}, 2);

    // R10 priority: pins 1 and 2 then 0
    wr(2'd1, 3'b111); wr(2'd0, 6'b00_01_10);
    set_pin(2, 0); cyc(4); check_all("R10 pins 1,2");
    chk(cpu_id == 1, "R10 lowest index", cpu_id, 1);
    set_pin(0, 0); cyc(4); check_all("R10 pin 0 wins");
    chk(cpu_id == 0, "R10 lowest index", cpu_id, 0);

    // R7 master enable off
    wr(2'd3, 0); check_all("R7 master off");
    chk(cpu_irq == 0 && req == 0, "R7 no request", {req, cpu_irq}, 0);
    wr(2'd3, 1);

    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0, 1, 2: set_pin($urandom % N, 1'($urandom));
        3: wr(2'd0, (2*N)'($urandom));
        4: wr(2'd1, (2*N)'($urandom));
        5: wr(2'd3, (2*N)'($urandom % 4 != 0));
        6: wr(2'd2, (2*N)'($urandom));
        default: do_ack(IDW'($urandom));
      endcase
      cyc(4);
      check_all("random model");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule